// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the byte-wide programming and readback port of a single eight-line priority interrupt controller. Software reaches it through one address bit, write and read strobes and an eight-bit data bus. It holds the programmable state of the controller: the line mask, the in-service set, the vector base, the rotation base and the mode flags. A small priority resolver inside it picks the line that should interrupt the processor.

The request vector arrives already latched from an external edge/level stage. When the block consumes a request, it returns a one-cycle clear pulse for that line. A processor acknowledge strobe takes the current winner and returns its vector. A poll read does the same work through the data bus.

Setup is a chain of two to four words. The first word says how long the chain is. After setup, writes to address 0 are end-of-interrupt, rotation or read-mode commands, and writes to address 1 load the mask.

Top module: `pic_regif_top`

## Requirements
- R1: After reset the mask, in-service set, rotation base, vector base and all mode flags are zero, and the read selector points at the request vector. `int_o`, `lvl_err_o`, `req_clr_o`, `vec_o` and `rdata_o` are 0.
- R2: A write to address 0 with bit 4 set restarts setup.
  - It clears the mask, the in-service set, the rotation base and every mode flag, including a pending poll.
  - It keeps `int_o` low until the setup chain ends.
  - It loads `lvl_err_o` from bit 3. Only the next setup word 1 changes `lvl_err_o` again.
- R3: The setup chain runs as follows.
  - The next address-1 write sets the vector base to data AND 0xF8.
  - One more address-1 word (the cascade word, which is ignored) follows unless bit 1 of the first word was set.
  - A fourth word follows only if bit 0 of the first word was set. That word sets `sfnm_o` from bit 4 and auto-EOI from bit 1.
- R4: Outside setup, an address-1 write loads the mask, and an address-1 read returns it.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a read-mode command.
  - Bit 2 arms poll.
  - Bit 1 allows bit 0 to choose the address-0 read: 1 returns the in-service set, 0 returns the request vector.
  - Bit 6 allows bit 5 to set special mask. Under special mask, masked lines are left out of the in-service set when priority is compared.
- R6: Priority falls from the rotation base upward, modulo 8. The winner is the highest-priority unmasked request. `int_o` is 1 only when the winner ranks strictly above the highest-priority in-service line.
- R7: An acknowledge works on the current winner.
  - If there is a winner, `vec_o` becomes vector base OR line, `req_clr_o` pulses that line's bit, and the line enters the in-service set.
  - If there is no winner, `vec_o` becomes vector base OR 7 and nothing else changes.
- R8: With auto-EOI on, an acknowledge leaves the in-service set unchanged. If rotate-on-auto-EOI is also set, the rotation base becomes line+1 modulo 8.
- R9: The command code is address-0 data bits 7:5 (with bits 4 and 3 clear).
  - Code 1 clears the highest-priority in-service bit.
  - Code 5 does the same and also sets the rotation base to that line+1.
  - Neither code has any effect when the in-service set is empty.
- R10: More command codes:
  - Code 3 clears the in-service bit named by data bits 2:0.
  - Code 7 does the same and sets the rotation base to that line+1.
  - Code 6 sets the rotation base to bits 2:0 plus 1.
  - Code 2 changes nothing.
- R11: Codes 0 and 4 set rotate-on-auto-EOI from data bit 7.
- R12: A read with poll armed returns the winning line number in `rdata_o`, pulses `req_clr_o` for that line and clears its in-service bit. If there is no winner, the read returns 7 and clears nothing. Poll then disarms, and the next read returns a register again.
- R13: Only one strobe takes effect per cycle. A write beats a read, and a read beats an acknowledge. `rdata_o`, `vec_o` and `req_clr_o` update on the clock edge that samples the strobe. `int_o` follows state and `req_i` with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| ack_i | input | 1 | Processor acknowledge strobe |
| vec_o | output | 8 | Vector captured by the last acknowledge |
| req_i | input | 8 | Latched request vector |
| req_clr_o | output | 8 | One-cycle clear pulse for a consumed request |
| int_o | output | 1 | Interrupt to the processor |
| sfnm_o | output | 1 | Special fully nested mode flag |
| lvl_err_o | output | 1 | Setup asked for level-sensitive mode |

## Verification
The bench runs every setup-chain variant and then a mask write with a readback. A decoder that takes one word too few or too many would put the mask value into the wrong setup slot, and the readback would differ.

It sweeps all eight rotation bases against several request and mask patterns, with two nested acknowledges and specific end-of-interrupt commands. An off-by-one in the modulo rotation, or a `<=` where `<` belongs in the nesting comparison, shows up as a wrong vector or a wrong `int_o`.

Directed parts cover the following:
- Non-specific end-of-interrupt clearing the highest-priority in-service line rather than the lowest-numbered one.
- Auto-EOI rotation walking the base.
- Special mask releasing a masked in-service line.
- Poll disarming after one read.
- An acknowledge that coincides with a write being dropped.

// File: rtl/pic_regif_pkg.sv
package pic_regif_pkg;

    localparam int PIC_LINES = 8;
    localparam int PIC_LW    = $clog2(PIC_LINES);
    localparam int PIC_DW    = 8;

    typedef enum logic [1:0] {
        STEP_RUN  = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } step_t;

    typedef struct packed {
        step_t                step;
        logic                 want_mode;
        logic                 solo;
        logic [PIC_DW-1:0]    vbase;
        logic [PIC_LINES-1:0] mask;
        logic [PIC_LINES-1:0] insvc;
        logic [PIC_LW-1:0]    rot;
        logic                 rd_insvc;
        logic                 poll;
        logic                 smask;
        logic                 aeoi;
        logic                 rot_aeoi;
        logic                 sfnm;
        logic                 lvl_err;
        logic [PIC_DW-1:0]    rdata;
        logic [PIC_DW-1:0]    vec;
        logic [PIC_LINES-1:0] clr;
    } regif_state_t;

endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int LINES = 8,
    parameter int LW    = $clog2(LINES)
) (
    input  logic [LINES-1:0] mask_i,
    input  logic [LW-1:0]    rot_i,
    output logic             found_o,
    output logic [LW-1:0]    prio_o
);
    logic [LINES-1:0] rotated;

    // rotated[p] is the line with priority rank p
    always_comb begin
        for (int p = 0; p < LINES; p++) begin
            rotated[p] = mask_i[LW'(p + int'(rot_i))];
        end
    end

    always_comb begin
        found_o = 1'b0;
        prio_o  = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            if (rotated[p]) begin
                found_o = 1'b1;
                prio_o  = LW'(p);
            end
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int LINES = 8,
    parameter int LW    = $clog2(LINES)
) (
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] insvc_i,
    input  logic [LW-1:0]    rot_i,
    input  logic             smask_i,
    output logic             win_o,
    output logic [LW-1:0]    win_line_o,
    output logic             busy_o,
    output logic [LW-1:0]    top_line_o
);
    localparam int N_PICK = 3;

    logic [LINES-1:0] pick_mask [N_PICK];
    logic             pick_found[N_PICK];
    logic [LW-1:0]    pick_prio [N_PICK];

    // 0: pending unmasked requests, 1: in-service view for nesting,
    // 2: raw in-service set for non-specific end of interrupt
    assign pick_mask[0] = req_i & ~mask_i;
    assign pick_mask[1] = smask_i ? (insvc_i & ~mask_i) : insvc_i;
    assign pick_mask[2] = insvc_i;

    for (genvar g = 0; g < N_PICK; g++) begin : g_pick
        pic_prio_pick #(.LINES(LINES), .LW(LW)) u_pick (
            .mask_i (pick_mask[g]),
            .rot_i  (rot_i),
            .found_o(pick_found[g]),
            .prio_o (pick_prio[g])
        );
    end

    assign win_o      = pick_found[0] & (~pick_found[1] | (pick_prio[0] < pick_prio[1]));
    assign win_line_o = pick_prio[0] + rot_i;
    assign busy_o     = pick_found[2];
    assign top_line_o = pick_prio[2] + rot_i;
endmodule

// File: rtl/pic_regif_top.sv
module pic_regif_top
    import pic_regif_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic                 addr_i,
    input  logic [PIC_DW-1:0]    wdata_i,
    output logic [PIC_DW-1:0]    rdata_o,
    input  logic                 ack_i,
    output logic [PIC_DW-1:0]    vec_o,
    input  logic [PIC_LINES-1:0] req_i,
    output logic [PIC_LINES-1:0] req_clr_o,
    output logic                 int_o,
    output logic                 sfnm_o,
    output logic                 lvl_err_o
);
    localparam logic [PIC_DW-1:0] BASE_KEEP = ~PIC_DW'(PIC_LINES - 1);
    localparam logic [PIC_DW-1:0] NONE_CODE = PIC_DW'(PIC_LINES - 1);

    regif_state_t state_d, state_q;

    logic              win;
    logic [PIC_LW-1:0] win_line;
    logic              busy;
    logic [PIC_LW-1:0] top_line;
    logic              init_wr;
    logic              init_busy;
    logic [PIC_LW-1:0] cmd_line;
    logic [2:0]        cmd_code;

    pic_arbiter #(.LINES(PIC_LINES), .LW(PIC_LW)) u_arb (
        .req_i     (req_i),
        .mask_i    (state_q.mask),
        .insvc_i   (state_q.insvc),
        .rot_i     (state_q.rot),
        .smask_i   (state_q.smask),
        .win_o     (win),
        .win_line_o(win_line),
        .busy_o    (busy),
        .top_line_o(top_line)
    );

    assign init_wr   = wr_i & ~addr_i & wdata_i[4];
    assign init_busy = (state_q.step != STEP_RUN);
    assign cmd_line  = wdata_i[PIC_LW-1:0];
    assign cmd_code  = wdata_i[7:5];

    always_comb begin
        state_d     = state_q;
        state_d.clr = '0;
        if (wr_i) begin
            if (init_wr) begin
                state_d.step      = STEP_BASE;
                state_d.want_mode = wdata_i[0];
                state_d.solo      = wdata_i[1];
                state_d.lvl_err   = wdata_i[3];
                state_d.vbase     = '0;
                state_d.mask      = '0;
                state_d.insvc     = '0;
                state_d.rot       = '0;
                state_d.rd_insvc  = 1'b0;
                state_d.poll      = 1'b0;
                state_d.smask     = 1'b0;
                state_d.aeoi      = 1'b0;
                state_d.rot_aeoi  = 1'b0;
                state_d.sfnm      = 1'b0;
            end else if (!addr_i && wdata_i[3]) begin
                if (wdata_i[2]) state_d.poll     = 1'b1;
                if (wdata_i[1]) state_d.rd_insvc = wdata_i[0];
                if (wdata_i[6]) state_d.smask    = wdata_i[5];
            end else if (!addr_i) begin
                case (cmd_code)
                    3'd0, 3'd4: state_d.rot_aeoi = wdata_i[7];
                    3'd1, 3'd5: begin
                        if (busy) begin
                            state_d.insvc[top_line] = 1'b0;
                            if (cmd_code[2]) state_d.rot = top_line + 1'b1;
                        end
                    end
                    3'd3, 3'd7: begin
                        state_d.insvc[cmd_line] = 1'b0;
                        if (cmd_code[2]) state_d.rot = cmd_line + 1'b1;
                    end
                    3'd6:    state_d.rot = cmd_line + 1'b1;
                    default: ;
                endcase
            end else begin
                case (state_q.step)
                    STEP_RUN: state_d.mask = wdata_i;
                    STEP_BASE: begin
                        state_d.vbase = wdata_i & BASE_KEEP;
                        if (!state_q.solo)          state_d.step = STEP_CASC;
                        else if (state_q.want_mode) state_d.step = STEP_MODE;
                        else                        state_d.step = STEP_RUN;
                    end
                    STEP_CASC: state_d.step = state_q.want_mode ? STEP_MODE : STEP_RUN;
                    default: begin
                        state_d.sfnm = wdata_i[4];
                        state_d.aeoi = wdata_i[1];
                        state_d.step = STEP_RUN;
                    end
                endcase
            end
        end else if (rd_i) begin
            if (state_q.poll) begin
                state_d.poll = 1'b0;
                if (win) begin
                    state_d.rdata           = PIC_DW'(win_line);
                    state_d.insvc[win_line] = 1'b0;
                    state_d.clr[win_line]   = 1'b1;
                end else begin
                    state_d.rdata = NONE_CODE;
                end
            end else if (addr_i) begin
                state_d.rdata = state_q.mask;
            end else begin
                state_d.rdata = state_q.rd_insvc ? state_q.insvc : req_i;
            end
        end else if (ack_i) begin
            if (win) begin
                state_d.vec           = state_q.vbase | PIC_DW'(win_line);
                state_d.clr[win_line] = 1'b1;
                if (!state_q.aeoi)          state_d.insvc[win_line] = 1'b1;
                else if (state_q.rot_aeoi)  state_d.rot = win_line + 1'b1;
            end else begin
                state_d.vec = state_q.vbase | NONE_CODE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign rdata_o   = state_q.rdata;
    assign vec_o     = state_q.vec;
    assign req_clr_o = state_q.clr;
    assign int_o     = win & ~init_busy;
    assign sfnm_o    = state_q.sfnm;
    assign lvl_err_o = state_q.lvl_err;
endmodule

// File: rtl/pic_regif_chk.sv
module pic_regif_chk #(
    parameter int LINES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_i,
    input logic             rd_i,
    input logic             ack_i,
    input logic             init_wr,
    input logic             init_busy,
    input logic             int_o,
    input logic [LINES-1:0] req_i,
    input logic [LINES-1:0] req_clr_o
);
    assert_init_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_wr |=> (init_busy && !int_o));

    assert_int_needs_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |-> (req_i != '0));

    assert_clr_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(req_clr_o));

    assert_clr_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_clr_o != '0) |-> $past(rd_i || ack_i));

    assert_write_wins_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (req_clr_o == '0));
endmodule

bind pic_regif_top pic_regif_chk #(.LINES(pic_regif_pkg::PIC_LINES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .ack_i    (ack_i),
    .init_wr  (init_wr),
    .init_busy(init_busy),
    .int_o    (int_o),
    .req_i    (req_i),
    .req_clr_o(req_clr_o)
);

// File: tb/pic_regif_top_bench.sv
module pic_regif_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, ack = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, req = '0;
    logic [7:0] rdata, vec, req_clr;
    logic       int_o, sfnm, lvl_err;

    int n_chk = 0, n_err = 0;

    // bench-side expectation state
    logic [7:0] m_imr, m_isr, m_vbase;
    int         m_rot;
    logic       m_smm, m_aeoi, m_raeoi;

    always #4 clk = ~clk;

    pic_regif_top u_pic_regif_top (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .vec_o(vec),
        .req_i(req), .req_clr_o(req_clr), .int_o(int_o), .sfnm_o(sfnm),
        .lvl_err_o(lvl_err)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rank(logic [7:0] m);
        for (int p = 0; p < 8; p++) if (m[(p + m_rot) % 8]) return p;
        return 8;
    endfunction

    function automatic int winner();
        int pr, pc;
        logic [7:0] iv;
        pr = rank(req & ~m_imr);
        if (pr == 8) return -1;
        iv = m_smm ? (m_isr & ~m_imr) : m_isr;
        pc = rank(iv);
        return (pr < pc) ? (pr + m_rot) % 8 : -1;
    endfunction

    task automatic bus_wr(bit a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(bit a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic set_req(logic [7:0] v);
        @(negedge clk); req = v; #1;
    endtask

    task automatic do_ack(string tag);
        int w;
        w = winner();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        if (w >= 0) begin
            chk({tag, " vec"}, vec, m_vbase | 8'(w));
            chk({tag, " clr"}, req_clr, 1 << w);
            if (!m_aeoi) m_isr[w] = 1'b1;
            else if (m_raeoi) m_rot = (w + 1) % 8;
        end else begin
            chk({tag, " spurious vec"}, vec, m_vbase | 8'h07);
            chk({tag, " spurious clr"}, req_clr, 0);
        end
        chk({tag, " int after ack"}, int_o, winner() >= 0);
    endtask

    task automatic init_seq(logic [7:0] w1, logic [7:0] w2, logic [7:0] w3, logic [7:0] w4);
        bus_wr(0, w1);
        bus_wr(1, w2);
        if (!w1[1]) bus_wr(1, w3);
        if (w1[0]) bus_wr(1, w4);
        m_imr = '0; m_isr = '0; m_rot = 0; m_smm = 0; m_raeoi = 0;
        m_vbase = w2 & 8'hF8;
        m_aeoi = w1[0] ? w4[1] : 1'b0;
    endtask

    task automatic rd_isr(output logic [7:0] v);
        bus_wr(0, 8'h0B);
        bus_rd(0, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pats [6];
        pats = '{8'h01, 8'h80, 8'h24, 8'hFF, 8'h90, 8'h00};
        m_imr = '0; m_isr = '0; m_vbase = '0; m_rot = 0;
        m_smm = 0; m_aeoi = 0; m_raeoi = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 int", int_o, 0);
        chk("R1 lvl_err", lvl_err, 0);
        chk("R1 vec", vec, 0);
        chk("R1 clr", req_clr, 0);
        bus_rd(1, v); chk("R1 mask", v, 0);
        set_req(8'h5A);
        bus_rd(0, v); chk("R1 read select irr", v, 8'h5A);

        // R2 int held low through the full chain, R3 four-word chain
        set_req(8'hFF);
        bus_wr(0, 8'h11); chk("R2 int low word1", int_o, 0);
        bus_wr(1, 8'h27); chk("R2 int low word2", int_o, 0);
        bus_wr(1, 8'h04); chk("R2 int low word3", int_o, 0);
        bus_wr(1, 8'h10); chk("R3 int after chain", int_o, 1);
        chk("R3 sfnm", sfnm, 1);
        m_imr = '0; m_isr = '0; m_rot = 0; m_smm = 0; m_raeoi = 0;
        m_vbase = 8'h20; m_aeoi = 0;
        bus_wr(1, 8'hA5); m_imr = 8'hA5;
        bus_rd(1, v); chk("R4 mask readback", v, 8'hA5);
        do_ack("R7 first");

        // R3 every chain length, then mask lands in the mask register
        for (int k = 0; k < 4; k++) begin
            init_seq(8'h10 | 8'(k), 8'h80 + 8'(k * 8) + 8'h03, 8'h00, 8'h00);
            bus_wr(1, 8'h3C ^ 8'(k)); m_imr = 8'h3C ^ 8'(k);
            bus_rd(1, v); chk("R3 chain length mask", v, 8'h3C ^ 8'(k));
            chk("R3 sfnm cleared", sfnm, 0);
            do_ack("R3 vector base");
        end

        // R2 level-sensitive flag
        init_seq(8'h1A, 8'h08, 8'h00, 8'h00);
        chk("R2 lvl_err set", lvl_err, 1);
        init_seq(8'h12, 8'h08, 8'h00, 8'h00);
        chk("R2 lvl_err cleared", lvl_err, 0);

        // R6 R7 sweep of rotation bases and patterns with nesting
        init_seq(8'h12, 8'h48, 8'h00, 8'h00);
        for (int r = 0; r < 8; r++) begin
            bus_wr(0, 8'hC0 | 8'((r + 7) % 8)); m_rot = r;
            for (int k = 0; k < 6; k++) begin
                bus_wr(1, (k == 3) ? 8'h0F : 8'h00);
                m_imr = (k == 3) ? 8'h0F : 8'h00;
                set_req(pats[k]);
                chk("R6 int", int_o, winner() >= 0);
                do_ack("R7 sweep a");
                do_ack("R7 sweep b");
                for (int l = 0; l < 8; l++) begin
                    if (m_isr[l]) begin
                        bus_wr(0, 8'h60 | 8'(l)); m_isr[l] = 1'b0;
                    end
                end
                chk("R10 specific clear int", int_o, winner() >= 0);
            end
        end

        // R9 non-specific end of interrupt
        bus_wr(0, 8'hC7); m_rot = 0;
        bus_wr(1, 8'h00); m_imr = '0;
        set_req(8'h28);
        do_ack("R9 line3");
        chk("R6 lower rank blocked", int_o, 0);
        set_req(8'h29);
        chk("R6 higher rank passes", int_o, 1);
        do_ack("R9 line0");
        bus_wr(0, 8'h20); m_isr = 8'h08;
        rd_isr(v); chk("R9 code1 clears top", v, 8'h08);
        bus_wr(0, 8'hA0); m_isr = 8'h00; m_rot = 4;
        rd_isr(v); chk("R9 code5 clears", v, 8'h00);
        do_ack("R9 rotated");
        chk("R9 rotated vector", vec, 8'h4D);
        bus_wr(0, 8'h00); bus_wr(0, 8'h20);
        bus_wr(0, 8'h20); m_isr = 8'h00;
        rd_isr(v); chk("R9 code1 empty", v, 8'h00);
        set_req(8'h29);
        do_ack("R9 reload");
        chk("R9 rotation kept", vec, 8'h4D);

        // R10 remaining commands
        bus_wr(0, 8'h40);
        rd_isr(v); chk("R10 code2 no effect", v, 8'h20);
        bus_wr(0, 8'hE5); m_isr = 8'h00; m_rot = 6;
        rd_isr(v); chk("R10 code7 clears", v, 8'h00);
        do_ack("R10 after code7");
        chk("R10 code7 rotation", vec, 8'h48);
        bus_wr(0, 8'h60); m_isr = 8'h00;
        rd_isr(v); chk("R10 code3 clears", v, 8'h00);
        bus_wr(0, 8'hC2); m_rot = 3;
        do_ack("R10 after code6");
        chk("R10 code6 rotation", vec, 8'h4B);
        bus_wr(0, 8'h63); m_isr = 8'h00;

        // R8 R11 auto-EOI with and without rotation
        init_seq(8'h13, 8'h48, 8'h00, 8'h02);
        bus_wr(0, 8'h80); m_raeoi = 1;
        set_req(8'h06);
        do_ack("R8 a"); chk("R8 first line", vec, 8'h49);
        rd_isr(v); chk("R8 no in-service", v, 8'h00);
        do_ack("R8 b"); chk("R8 rotated line", vec, 8'h4A);
        do_ack("R8 c"); chk("R8 wrapped line", vec, 8'h49);
        bus_wr(0, 8'h00); m_raeoi = 0;
        do_ack("R11 d"); chk("R11 rotation off", vec, 8'h4A);
        do_ack("R11 e"); chk("R11 base held", vec, 8'h4A);

        // R5 special mask and read select
        init_seq(8'h12, 8'h48, 8'h00, 8'h00);
        set_req(8'h04);
        do_ack("R5 setup");
        bus_wr(1, 8'h04); m_imr = 8'h04;
        set_req(8'h24);
        chk("R5 blocked without special mask", int_o, 0);
        bus_wr(0, 8'h68); m_smm = 1;
        chk("R5 special mask releases", int_o, 1);
        bus_wr(0, 8'h48); m_smm = 0;
        chk("R5 special mask off", int_o, 0);
        bus_wr(0, 8'h0A);
        bus_rd(0, v); chk("R5 read irr", v, 8'h24);
        bus_wr(0, 8'h0B);
        bus_rd(0, v); chk("R5 read isr", v, 8'h04);
        bus_wr(0, 8'h08);
        bus_rd(0, v); chk("R5 select held without bit1", v, 8'h04);

        // R12 poll
        bus_wr(0, 8'h62); m_isr = 8'h00;
        bus_wr(1, 8'h00); m_imr = 8'h00;
        bus_wr(0, 8'h0C);
        bus_rd(1, v);
        chk("R12 poll line", v, 2);
        chk("R12 poll clr", req_clr, 8'h04);
        bus_rd(1, v); chk("R12 poll disarmed", v, 8'h00);
        rd_isr(v); chk("R12 poll no in-service", v, 8'h00);
        bus_wr(1, 8'hFF); m_imr = 8'hFF;
        bus_wr(0, 8'h0C);
        bus_rd(0, v);
        chk("R12 poll none", v, 7);
        chk("R12 poll none clr", req_clr, 0);

        // R13 strobe priority
        bus_wr(1, 8'h00); m_imr = 8'h00;
        @(negedge clk); addr = 1; wdata = 8'h00; wr = 1; ack = 1;
        @(negedge clk); wr = 0; ack = 0;
        chk("R13 write beats ack clr", req_clr, 0);
        chk("R13 write beats ack vec", vec, 8'h4A);
        @(negedge clk); addr = 1; rd = 1; ack = 1;
        @(negedge clk); rd = 0; ack = 0;
        chk("R13 read beats ack clr", req_clr, 0);
        chk("R13 read data", rdata, 8'h00);
        rd_isr(v); chk("R13 no in-service", v, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule